// File: doc/BRIEF.md
# Stream-to-Memory Burst Writer

This block takes an unbroken stream of 64-bit sample words and stores them in system memory through a memory-mapped write master. It writes only in fixed bursts of 128 bytes. Incoming words wait in a small internal FIFO. A burst begins only when the FIFO holds enough words to complete it.

Software supplies two run-time values. The first is a base byte address for the buffer. The second is the highest burst index the write pointer may reach. Burst n lands at base + 128·n. After the burst at the highest index completes, the index returns to zero, so the buffer acts as a ring of (limit+1)·128 bytes. For example, a limit of 262143 gives 32 MB. The live burst index is always present on a status output. Software can read it to see how far committed data reaches. The index moves forward only when the write response for a burst arrives.

Top module: `stream_burst_writer`

## Requirements
- R1: Burst n is written at address `cfg_base + 128*n`, where n is the burst index when the address is issued. Every address request carries length 15 (`m_awlen`=15), beat size code 3 (`m_awsize`=3, eight bytes) and incrementing type (`m_awburst`=2'b01).
- R2: Each burst has exactly 16 data beats. `m_wstrb` is all ones on every beat. `m_wlast` is high on the 16th beat and low on the others.
- R3: The block raises no address request until at least 16 words are buffered. The words leave on the data channel in the order the stream delivered them.
- R4: The FIFO holds 64 words. `s_tready` is low exactly when all 64 entries are occupied. No accepted word is ever lost.
- R5: `sts_count` shows the burst index. It rises by one in the cycle after a write response handshake and changes at no other time.
- R6: When a response completes a burst whose index is greater than or equal to `cfg_limit`, the index returns to 0. The next burst is then written at `cfg_base`.
- R7: Only one burst is in flight. The block issues no new address request until the response for the previous burst has been received.
- R8: While `rst` is high at a clock edge, the burst index and the FIFO are cleared and `m_awvalid` and `m_wvalid` drop. `m_bready` stays high at all times.
- R9: Once `m_awvalid` or `m_wvalid` is raised, it stays high with an unchanged address, data and last flag until the matching ready is seen.
- R10: A new `cfg_base` or `cfg_limit` written while the block is idle applies to the next burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_base | input | ADDR_W | Buffer base byte address |
| cfg_limit | input | CNT_W | Highest burst index before wrap |
| sts_count | output | CNT_W | Live burst index |
| s_tdata | input | DATA_W | Stream sample word |
| s_tvalid | input | 1 | Stream word valid |
| s_tready | output | 1 | FIFO can accept a word |
| m_awaddr | output | ADDR_W | Burst start address |
| m_awlen | output | 8 | Beats per burst minus one |
| m_awsize | output | 3 | Beat size code |
| m_awburst | output | 2 | Burst type (incrementing) |
| m_awvalid | output | 1 | Address request valid |
| m_awready | input | 1 | Address request accepted |
| m_wdata | output | DATA_W | Write data beat |
| m_wstrb | output | DATA_W/8 | Byte enables |
| m_wlast | output | 1 | Final beat of burst |
| m_wvalid | output | 1 | Write beat valid |
| m_wready | input | 1 | Write beat accepted |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Response accept (always high) |

## Verification
The properties assume a well-behaved memory slave. It raises `m_bvalid` only after a burst's last beat has been taken, and only once per burst. The properties also assume the two configuration inputs change only while no burst is pending. The bench's slave model gives each response exactly once, after a short random delay that follows the last-beat handshake. Ready signals are toggled at random but never withdraw a handshake. The bench alters base and limit only after the FIFO has drained below one burst and no response is outstanding.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_RESP
  } sbw_state_e;

  localparam logic [1:0] BURST_INCR = 2'b01;
endpackage

// File: rtl/sbw_fifo.sv
module sbw_fifo #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [LVL_W-1:0] level,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, rd_ptr_nxt;

  assign full       = (level == LVL_W'(DEPTH));
  assign rd_ptr_nxt = pop ? rd_ptr + 1'b1 : rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  // head word is kept in an output register; a write to the slot about to
  // become the head is forwarded so the register never holds stale data
  always_ff @(posedge clk) begin
    if (push && (wr_ptr == rd_ptr_nxt)) dout <= din;
    else                                dout <= mem[rd_ptr_nxt];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      rd_ptr <= rd_ptr_nxt;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/sbw_addr_gen.sv
module sbw_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 20,
  parameter int SHIFT  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  limit,
  input  logic              advance,
  output logic [CNT_W-1:0]  count,
  output logic [ADDR_W-1:0] addr
);
  assign addr = base + (ADDR_W'(count) << SHIFT);

  always_ff @(posedge clk) begin
    if (rst)          count <= '0;
    else if (advance) count <= (count >= limit) ? '0 : count + 1'b1;
  end
endmodule

// File: rtl/sbw_burst_ctrl.sv
module sbw_burst_ctrl import sbw_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int BEATS  = 16,
  parameter int LVL_W  = 7,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LVL_W-1:0]  level,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] awaddr,
  output logic              awvalid,
  input  logic              awready,
  output logic              wvalid,
  input  logic              wready,
  output logic              wlast,
  output logic              pop,
  input  logic              bvalid,
  output logic              advance
);
  sbw_state_e        state;
  logic [BEAT_W-1:0] beat;

  assign pop     = wvalid && wready;
  assign advance = (state == ST_RESP) && bvalid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      awvalid <= 1'b0;
      wvalid  <= 1'b0;
      wlast   <= 1'b0;
      beat    <= '0;
      awaddr  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (level >= LVL_W'(BEATS)) begin
          awaddr  <= addr_in;
          awvalid <= 1'b1;
          state   <= ST_ADDR;
        end
        ST_ADDR: if (awready) begin
          awvalid <= 1'b0;
          wvalid  <= 1'b1;
          wlast   <= 1'b0;
          beat    <= '0;
          state   <= ST_DATA;
        end
        ST_DATA: if (wready) begin
          if (wlast) begin
            wvalid <= 1'b0;
            wlast  <= 1'b0;
            state  <= ST_RESP;
          end else begin
            beat  <= beat + 1'b1;
            wlast <= (beat == BEAT_W'(BEATS - 2));
          end
        end
        ST_RESP: if (bvalid) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stream_burst_writer.sv
module stream_burst_writer import sbw_pkg::*; #(
  parameter int DATA_W      = 64,
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 20,
  parameter int FIFO_DEPTH  = 64,
  parameter int BURST_BEATS = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   cfg_base,
  input  logic [CNT_W-1:0]    cfg_limit,
  output logic [CNT_W-1:0]    sts_count,
  input  logic [DATA_W-1:0]   s_tdata,
  input  logic                s_tvalid,
  output logic                s_tready,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic [7:0]          m_awlen,
  output logic [2:0]          m_awsize,
  output logic [1:0]          m_awburst,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_wlast,
  output logic                m_wvalid,
  input  logic                m_wready,
  input  logic                m_bvalid,
  output logic                m_bready
);
  localparam int BYTES       = DATA_W / 8;
  localparam int BURST_SHIFT = $clog2(BURST_BEATS * BYTES);
  localparam int LVL_W       = $clog2(FIFO_DEPTH) + 1;

  logic [LVL_W-1:0]  fifo_level;
  logic              fifo_full, fifo_push, fifo_pop, advance;
  logic [ADDR_W-1:0] next_addr;

  assign s_tready  = !fifo_full;
  assign fifo_push = s_tvalid && !fifo_full;
  assign m_awlen   = 8'(BURST_BEATS - 1);
  assign m_awsize  = 3'($clog2(BYTES));
  assign m_awburst = BURST_INCR;
  assign m_wstrb   = '1;
  assign m_bready  = 1'b1;

  sbw_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(fifo_push), .din(s_tdata), .pop(fifo_pop),
    .dout(m_wdata), .level(fifo_level), .full(fifo_full)
  );

  sbw_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SHIFT(BURST_SHIFT)) u_addr (
    .clk(clk), .rst(rst), .base(cfg_base), .limit(cfg_limit),
    .advance(advance), .count(sts_count), .addr(next_addr)
  );

  sbw_burst_ctrl #(.ADDR_W(ADDR_W), .BEATS(BURST_BEATS), .LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rst(rst), .level(fifo_level), .addr_in(next_addr),
    .awaddr(m_awaddr), .awvalid(m_awvalid), .awready(m_awready),
    .wvalid(m_wvalid), .wready(m_wready), .wlast(m_wlast), .pop(fifo_pop),
    .bvalid(m_bvalid), .advance(advance)
  );
endmodule

// File: rtl/sbw_checker.sv
module sbw_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 20,
  parameter int DEPTH  = 64,
  parameter int BEATS  = 16,
  parameter int LVL_W  = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              m_awvalid,
  input logic              m_awready,
  input logic [ADDR_W-1:0] m_awaddr,
  input logic              m_wvalid,
  input logic              m_wready,
  input logic              m_wlast,
  input logic [DATA_W-1:0] m_wdata,
  input logic              m_bvalid,
  input logic              m_bready,
  input logic [CNT_W-1:0]  sts_count,
  input logic [LVL_W-1:0]  fifo_level
);
  logic [7:0] beats_seen;
  logic       in_flight;

  always_ff @(posedge clk) begin
    if (rst) begin
      beats_seen <= '0;
      in_flight  <= 1'b0;
    end else begin
      if (m_wvalid && m_wready) beats_seen <= m_wlast ? '0 : beats_seen + 1'b1;
      if (m_awvalid && m_awready)    in_flight <= 1'b1;
      else if (m_bvalid && m_bready) in_flight <= 1'b0;
    end
  end

  assert_aw_hold_R9: assert property (@(posedge clk) disable iff (rst)
    m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr));
  assert_w_hold_R9: assert property (@(posedge clk) disable iff (rst)
    m_wvalid && !m_wready |=> m_wvalid && $stable(m_wdata) && $stable(m_wlast));
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    fifo_level <= LVL_W'(DEPTH));
  assert_aw_needs_data_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(m_awvalid) |-> fifo_level >= LVL_W'(BEATS));
  assert_single_burst_R7: assert property (@(posedge clk) disable iff (rst)
    m_awvalid |-> !in_flight && !m_wvalid);
  assert_last_on_final_R2: assert property (@(posedge clk) disable iff (rst)
    m_wvalid && m_wready |-> (m_wlast == (beats_seen == 8'(BEATS - 1))));
  assert_count_moves_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(sts_count) |-> $past(m_bvalid && m_bready));
  assert_count_step_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(sts_count) |-> (sts_count == '0) || (sts_count == $past(sts_count) + 1'b1));
  assert_reset_clear_R8: assert property (@(posedge clk)
    $past(rst) |-> !m_awvalid && !m_wvalid && sts_count == '0 && fifo_level == '0);
  assert_bready_R8: assert property (@(posedge clk) disable iff (rst) m_bready);
endmodule

bind stream_burst_writer sbw_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
  .DEPTH(FIFO_DEPTH), .BEATS(BURST_BEATS), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rst(rst), .m_awvalid(m_awvalid), .m_awready(m_awready),
  .m_awaddr(m_awaddr), .m_wvalid(m_wvalid), .m_wready(m_wready),
  .m_wlast(m_wlast), .m_wdata(m_wdata), .m_bvalid(m_bvalid),
  .m_bready(m_bready), .sts_count(sts_count), .fifo_level(fifo_level)
);

// File: tb/sim_stream_burst_writer.sv
module sim_stream_burst_writer;
  localparam int DATA_W = 64, ADDR_W = 32, CNT_W = 20, DEPTH = 64, BEATS = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1;
  logic [ADDR_W-1:0] cfg_base = 32'h1000_0000;
  logic [CNT_W-1:0]  cfg_limit = 20'd3;
  logic [CNT_W-1:0]  sts_count;
  logic [DATA_W-1:0] s_tdata = '0;
  logic s_tvalid = 1'b0, s_tready;
  logic [ADDR_W-1:0] m_awaddr;
  logic [7:0] m_awlen;
  logic [2:0] m_awsize;
  logic [1:0] m_awburst;
  logic m_awvalid, m_awready = 1'b0;
  logic [DATA_W-1:0] m_wdata;
  logic [DATA_W/8-1:0] m_wstrb;
  logic m_wlast, m_wvalid, m_wready = 1'b0;
  logic m_bvalid = 1'b0, m_bready;

  stream_burst_writer u0 (
    .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_limit(cfg_limit),
    .sts_count(sts_count), .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awsize(m_awsize), .m_awburst(m_awburst),
    .m_awvalid(m_awvalid), .m_awready(m_awready), .m_wdata(m_wdata), .m_wstrb(m_wstrb),
    .m_wlast(m_wlast), .m_wvalid(m_wvalid), .m_wready(m_wready),
    .m_bvalid(m_bvalid), .m_bready(m_bready)
  );

  int vectors = 0, miscompares = 0, cycles = 0;
  logic [DATA_W-1:0] q[$];
  int occ = 0, mcnt = 0, beat = 0, words_left = 0, bdelay = 0;
  bit outstanding = 0, bpend = 0, stall_aw = 0, prev_aw = 0;
  logic [DATA_W-1:0] next_word = 64'hA5A5_0000_0000_0001;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      chk(1'b0, "watchdog R5", 64'(cycles), 64'd150000);
      summary();
      $finish;
    end
  end

  // reference model, compared every cycle
  always @(negedge clk) begin
    s_tvalid  = !rst && words_left > 0 && ($urandom_range(3) != 0);
    s_tdata   = next_word;
    m_awready = !stall_aw && ($urandom_range(1) == 1);
    m_wready  = ($urandom_range(3) != 0);
    m_bvalid  = !rst && bpend && bdelay == 0;
    if (bpend && bdelay > 0) bdelay--;
    #1;
    if (rst) begin
      q.delete();
      occ = 0; mcnt = 0; outstanding = 0; beat = 0; bpend = 0; prev_aw = 0;
      m_bvalid = 1'b0;
    end else begin
      chk(sts_count == CNT_W'(mcnt), "R5 status", 64'(sts_count), 64'(mcnt));
      chk(s_tready == (occ < DEPTH), "R4 ready", 64'(s_tready), 64'(occ < DEPTH));
      chk(m_bready == 1'b1, "R8 bready", 64'(m_bready), 64'd1);
      if (m_awvalid && !prev_aw) chk(occ >= BEATS, "R3 early request", 64'(occ), 64'(BEATS));
      if (m_awvalid) chk(!outstanding, "R7 overlap", 64'(outstanding), 64'd0);
      if (s_tvalid && s_tready) begin
        q.push_back(s_tdata);
        occ++; next_word++; words_left--;
      end
      if (m_awvalid && m_awready) begin
        logic [ADDR_W-1:0] ea;
        ea = cfg_base + ADDR_W'(mcnt) * 32'd128;
        chk(m_awaddr == ea, "R1 address", 64'(m_awaddr), 64'(ea));
        chk(m_awlen == 8'd15 && m_awsize == 3'd3 && m_awburst == 2'b01, "R1 attributes",
            64'({m_awlen, 1'b0, m_awsize, 2'b0, m_awburst}), 64'({8'd15, 1'b0, 3'd3, 2'b0, 2'b01}));
        outstanding = 1; beat = 0;
      end
      if (m_wvalid && m_wready) begin
        logic [DATA_W-1:0] ed;
        ed = (q.size() > 0) ? q.pop_front() : '0;
        occ--;
        chk(m_wdata == ed, "R3 order", m_wdata, ed);
        chk(&m_wstrb, "R2 strobe", 64'(m_wstrb), 64'hFF);
        chk(m_wlast == (beat == BEATS - 1), "R2 last", 64'(m_wlast), 64'(beat == BEATS - 1));
        beat++;
        if (m_wlast) begin
          bpend = 1; bdelay = $urandom_range(4);
        end
      end
      if (m_bvalid && m_bready) begin
        bpend = 0; outstanding = 0;
        mcnt = (CNT_W'(mcnt) >= cfg_limit) ? 0 : mcnt + 1;
      end
      prev_aw = m_awvalid;
    end
  end

  task automatic drain();
    while (words_left != 0 || occ >= BEATS || outstanding || m_awvalid) @(negedge clk);
    repeat (3) @(negedge clk);
    #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #2;
    // R8: state after reset
    chk(s_tready && !m_awvalid && !m_wvalid && sts_count == '0 && m_bready, "R8 reset state",
        64'({s_tready, m_awvalid, m_wvalid, m_bready}), 64'b1001);

    // ten bursts with limit 3: wraps twice (R6)
    words_left = 160;
    drain();
    chk(sts_count == 20'd2, "R6 ring wrap", 64'(sts_count), 64'd2);

    // R4: address channel stalled, FIFO fills
    stall_aw = 1; words_left = 100;
    repeat (250) @(negedge clk);
    #2;
    chk(!s_tready, "R4 full", 64'(s_tready), 64'd0);
    chk(words_left == 36, "R4 accepted", 64'(words_left), 64'd36);
    chk(sts_count == 20'd2, "R4 no progress while stalled", 64'(sts_count), 64'd2);
    stall_aw = 0;
    drain();
    chk(sts_count == 20'd0, "R6 wrap after stall", 64'(sts_count), 64'd0);

    // R3: 15 words buffered must not start a burst
    words_left = 11;
    while (words_left != 0) @(negedge clk);
    repeat (40) @(negedge clk);
    #2;
    chk(!m_awvalid && sts_count == 20'd0, "R3 partial hold", 64'(m_awvalid), 64'd0);
    words_left = 1;
    drain();
    chk(sts_count == 20'd1, "R3 burst on 16th word", 64'(sts_count), 64'd1);

    // R10 / R6: new base, limit below current index
    cfg_base = 32'h00A0_0000; cfg_limit = 20'd0;
    words_left = 48;
    drain();
    chk(sts_count == 20'd0, "R6 index above limit", 64'(sts_count), 64'd0);
    cfg_limit = 20'd262143;
    words_left = 32;
    drain();
    chk(sts_count == 20'd2, "R10 new limit", 64'(sts_count), 64'd2);

    // R8: reset in the middle of traffic
    words_left = 40;
    while (occ < 20) @(negedge clk);
    @(negedge clk) begin rst = 1'b1; words_left = 0; end
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #2;
    chk(sts_count == '0 && !m_awvalid && !m_wvalid && s_tready, "R8 mid reset",
        64'({sts_count, m_awvalid, m_wvalid}), 64'd0);
    words_left = 32;
    drain();
    chk(sts_count == 20'd2, "R5 after reset", 64'(sts_count), 64'd2);

    summary();
    $finish;
  end
endmodule